// File: doc/BRIEF.md
# Select-Coded Eight-Bit Arithmetic Logic Unit

This block is a purely combinational eight-bit arithmetic logic unit. A four-bit function code, a mode bit and an active-low carry input choose one of sixteen bitwise logic functions or one of sixteen arithmetic functions. Two operand words go in. The outputs are an eight-bit result, an active-low carry output and a flag that is high when every result bit is one. A datapath places it between its operand latches and its result bus and drives the function code from control.

Inside, the word is split into four-bit slices. Each bit cell first forms two select-shaped terms from its operand bits. In arithmetic mode the result is the sum of those terms plus the carry. In logic mode it is their exclusive-NOR. The carry ripples through each slice, and one slice's carry output feeds the next slice's carry input. The block has no registers and no handshake: outputs follow inputs within one combinational path. For that reason the stream-style valid/ready convention has no place here.

Top module: `alu8_fsel`

## Requirements
- R1: With logic_mode=1, result is the following function of fsel: 1111 A, 1110 A|B, 1101 A|~B, 1100 all ones, 1011 A&B, 1010 B, 1001 ~(A^B), 1000 ~A|B, 0111 A&~B, 0110 A^B, 0101 ~B, 0100 ~(A&B), 0011 all zeros, 0010 ~A&B, 0001 ~(A|B), 0000 ~A.
- R2: With logic_mode=0 and carry_in_n=1, result is the low eight bits of a sum chosen by fsel: 0000 A+0, 0001 (A|B)+0, 0010 (A|~B)+0, 0011 FF+0, 0100 A+(A&~B), 0101 (A|B)+(A&~B), 0110 A+~B, 0111 (A&~B)+FF, 1000 A+(A&B), 1001 A+B, 1010 (A|~B)+(A&B), 1011 (A&B)+FF, 1100 A+A, 1101 (A|B)+A, 1110 (A|~B)+A, 1111 A+FF.
- R3: With logic_mode=0 and carry_in_n=0, one is added to the R2 sum. For example fsel=0000 gives A+1.
- R4: In arithmetic mode, carry_out_n is the inverse of bit 8 of the nine-bit R2/R3 sum. A carry out of bit 3 reaches bit 4, so 0x0F+0x01 gives 0x10.
- R5: With logic_mode=1, carry_in_n has no effect on any output, and carry_out_n stays 1.
- R6: all_ones is 1 exactly when all eight result bits are 1. fsel=0110, logic_mode=0 and carry_in_n=1 with A equal to B raise it.
- R7: fsel=1001, logic_mode=0, carry_in_n=1 gives result = A+B with no carry added, and carry_out_n=0 when the sum exceeds 255.
- R8: fsel=0110, logic_mode=0, carry_in_n=0 gives result = A-B, with carry_out_n=0 when A is greater than or equal to B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 8 | Operand A |
| op_b | input | 8 | Operand B |
| fsel | input | 4 | Function code |
| logic_mode | input | 1 | 1 selects bitwise logic, 0 selects arithmetic |
| carry_in_n | input | 1 | Active-low carry into bit 0 |
| result | output | 8 | Function result |
| carry_out_n | output | 1 | Active-low carry out of bit 7 |
| all_ones | output | 1 | High when every result bit is one |

## Verification
Immediate assertions beside the logic watch, on every input change, the following:
- each slice's ripple result agrees with a word-level sum of its terms;
- carry_out_n is held high in logic mode;
- add, subtract, XOR and NOT behave as the named codes require;
- the equal-operand subtract raises all_ones.

Some behaviours only the bench scenarios can show. These are the full thirty-two-entry function tables under random operands with both carry_in_n values, the carry crossing the slice boundary, and the absence of any carry_in_n effect in logic mode.

// File: rtl/alu_fsel_pkg.sv
package alu_fsel_pkg;
  // function codes whose behaviour is checked by name
  localparam logic [3:0] FS_NOT_A   = 4'b0000;
  localparam logic [3:0] FS_XOR_SUB = 4'b0110;
  localparam logic [3:0] FS_ADD     = 4'b1001;

  // per-bit select terms of one cell
  typedef struct packed {
    logic x;
    logic y;
  } cell_terms_t;

  function automatic cell_terms_t form_terms(input logic a, input logic b,
                                             input logic [3:0] s);
    cell_terms_t t;
    t.x = a | (b & s[0]) | (~b & s[1]);
    t.y = (a & b & s[3]) | (a & ~b & s[2]);
    return t;
  endfunction
endpackage

// File: rtl/alu_fsel_cell.sv
module alu_fsel_cell
  import alu_fsel_pkg::*;
(
  input  logic       a,
  input  logic       b,
  input  logic [3:0] sel,
  input  logic       mode,
  input  logic       cin,
  output logic       x,
  output logic       y,
  output logic       f,
  output logic       cout
);
  cell_terms_t terms;

  always_comb begin
    terms = form_terms(a, b, sel);
    x     = terms.x;
    y     = terms.y;
    f     = mode ? ~(terms.x ^ terms.y) : (terms.x ^ terms.y ^ cin);
    cout  = (terms.x & terms.y) | ((terms.x ^ terms.y) & cin);
  end
endmodule

// File: rtl/alu_fsel_slice.sv
module alu_fsel_slice #(
  parameter int SLICE_W = 4
) (
  input  logic [SLICE_W-1:0] a,
  input  logic [SLICE_W-1:0] b,
  input  logic [3:0]         sel,
  input  logic               mode,
  input  logic               cin,
  output logic [SLICE_W-1:0] f,
  output logic               cout
);
  logic [SLICE_W:0]   chain;
  logic [SLICE_W-1:0] xv;
  logic [SLICE_W-1:0] yv;

  assign chain[0] = cin;

  for (genvar i = 0; i < SLICE_W; i++) begin : g_bit
    alu_fsel_cell u_cell (
      .a    (a[i]),
      .b    (b[i]),
      .sel  (sel),
      .mode (mode),
      .cin  (chain[i]),
      .x    (xv[i]),
      .y    (yv[i]),
      .f    (f[i]),
      .cout (chain[i+1])
    );
  end

  assign cout = chain[SLICE_W];

  // R2 R3 R4: ripple result equals the word-level sum of the slice terms
  always_comb begin
    if (!$isunknown({a, b, sel, mode, cin}) && !mode) begin
      a_r4_slice_sum: assert ({cout, f} == ({1'b0, xv} + {1'b0, yv} + {{SLICE_W{1'b0}}, cin}))
        else $error("slice ripple sum mismatch");
    end
  end
endmodule

// File: rtl/alu8_fsel.sv
module alu8_fsel
  import alu_fsel_pkg::*;
#(
  parameter int SLICE_W    = 4,
  parameter int NUM_SLICES = 2,
  localparam int DATA_W    = SLICE_W * NUM_SLICES
) (
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [3:0]        fsel,
  input  logic              logic_mode,
  input  logic              carry_in_n,
  output logic [DATA_W-1:0] result,
  output logic              carry_out_n,
  output logic              all_ones
);
  logic [NUM_SLICES:0] link;

  assign link[0] = ~carry_in_n;

  for (genvar k = 0; k < NUM_SLICES; k++) begin : g_slice
    alu_fsel_slice #(.SLICE_W(SLICE_W)) u_slice (
      .a    (op_a[k*SLICE_W +: SLICE_W]),
      .b    (op_b[k*SLICE_W +: SLICE_W]),
      .sel  (fsel),
      .mode (logic_mode),
      .cin  (link[k]),
      .f    (result[k*SLICE_W +: SLICE_W]),
      .cout (link[k+1])
    );
  end

  assign carry_out_n = logic_mode | ~link[NUM_SLICES];
  assign all_ones    = &result;

  always_comb begin
    if (!$isunknown({op_a, op_b, fsel, logic_mode, carry_in_n})) begin
      if (logic_mode) begin
        a_r5_no_carry_out: assert (carry_out_n == 1'b1)
          else $error("carry out active in logic mode");
      end
      if (logic_mode && fsel == FS_XOR_SUB) begin
        a_r1_xor: assert (result == (op_a ^ op_b))
          else $error("xor code wrong");
      end
      if (logic_mode && fsel == FS_NOT_A) begin
        a_r1_not_a: assert (result == ~op_a)
          else $error("not-a code wrong");
      end
      if (!logic_mode && fsel == FS_ADD && carry_in_n) begin
        a_r7_add: assert ({~carry_out_n, result} == ({1'b0, op_a} + {1'b0, op_b}))
          else $error("add code wrong");
      end
      if (!logic_mode && fsel == FS_XOR_SUB && !carry_in_n) begin
        a_r8_sub: assert (result == DATA_W'(op_a - op_b))
          else $error("subtract code wrong");
      end
      if (!logic_mode && fsel == FS_XOR_SUB && carry_in_n && op_a == op_b) begin
        a_r6_equal: assert (all_ones)
          else $error("equal operands did not raise flag");
      end
    end
  end
endmodule

// File: tb/sim_alu8_fsel.sv
module sim_alu8_fsel;
  logic       clk = 1'b0;
  logic [7:0] op_a = '0, op_b = '0;
  logic [3:0] fsel = '0;
  logic       logic_mode = 1'b0;
  logic       carry_in_n = 1'b1;
  logic [7:0] result;
  logic       carry_out_n, all_ones;
  int         n_checks = 0, n_fail = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  alu8_fsel u0 (
    .op_a(op_a), .op_b(op_b), .fsel(fsel), .logic_mode(logic_mode),
    .carry_in_n(carry_in_n), .result(result), .carry_out_n(carry_out_n),
    .all_ones(all_ones)
  );

  // reference: {carry_out_n, result}
  function automatic logic [8:0] ref_alu(input logic [7:0] a, input logic [7:0] b,
                                         input logic [3:0] s, input logic m,
                                         input logic cn);
    logic [7:0] p, q, r;
    logic [8:0] sum;
    if (m) begin
      case (s)
        4'b0000: r = ~a;        4'b0001: r = ~(a | b);
        4'b0010: r = ~a & b;    4'b0011: r = 8'h00;
        4'b0100: r = ~(a & b);  4'b0101: r = ~b;
        4'b0110: r = a ^ b;     4'b0111: r = a & ~b;
        4'b1000: r = ~a | b;    4'b1001: r = ~(a ^ b);
        4'b1010: r = b;         4'b1011: r = a & b;
        4'b1100: r = 8'hFF;     4'b1101: r = a | ~b;
        4'b1110: r = a | b;     default: r = a;
      endcase
      return {1'b1, r};
    end
    case (s)
      4'b0000: begin p = a;        q = 8'h00;   end
      4'b0001: begin p = a | b;    q = 8'h00;   end
      4'b0010: begin p = a | ~b;   q = 8'h00;   end
      4'b0011: begin p = 8'hFF;    q = 8'h00;   end
      4'b0100: begin p = a;        q = a & ~b;  end
      4'b0101: begin p = a | b;    q = a & ~b;  end
      4'b0110: begin p = a;        q = ~b;      end
      4'b0111: begin p = a & ~b;   q = 8'hFF;   end
      4'b1000: begin p = a;        q = a & b;   end
      4'b1001: begin p = a;        q = b;       end
      4'b1010: begin p = a | ~b;   q = a & b;   end
      4'b1011: begin p = a & b;    q = 8'hFF;   end
      4'b1100: begin p = a;        q = a;       end
      4'b1101: begin p = a | b;    q = a;       end
      4'b1110: begin p = a | ~b;   q = a;       end
      default: begin p = a;        q = 8'hFF;   end
    endcase
    sum = {1'b0, p} + {1'b0, q} + {8'h00, ~cn};
    return {~sum[8], sum[7:0]};
  endfunction

  task automatic apply(input logic [7:0] a, input logic [7:0] b, input logic [3:0] s,
                       input logic m, input logic cn);
    @(posedge clk);
    op_a = a; op_b = b; fsel = s; logic_mode = m; carry_in_n = cn;
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (a=%h b=%h s=%b m=%b cn=%b)",
               tag, act, exp, op_a, op_b, fsel, logic_mode, carry_in_n);
    end
  endtask

  task automatic check_full(input string tag);
    logic [8:0] e;
    e = ref_alu(op_a, op_b, fsel, logic_mode, carry_in_n);
    check(tag, {all_ones, carry_out_n, result}, {(e[7:0] == 8'hFF), e});
  endtask

  task automatic t_idle_state;
    apply(8'h00, 8'h00, 4'b0000, 1'b0, 1'b1);
    check("R2 idle zero inputs", {all_ones, carry_out_n, result}, {1'b0, 1'b1, 8'h00});
  endtask

  task automatic t_logic_table;  // R1
    for (int s = 0; s < 16; s++)
      for (int k = 0; k < 4; k++) begin
        apply(8'($urandom), 8'($urandom), 4'(s), 1'b1, 1'(k & 1));
        check_full("R1 logic table");
      end
  endtask

  task automatic t_arith_table;  // R2 R3 R4
    for (int s = 0; s < 16; s++)
      for (int k = 0; k < 6; k++) begin
        apply(8'($urandom), 8'($urandom), 4'(s), 1'b0, 1'(k & 1));
        check_full((k & 1) ? "R2 arith table" : "R3 arith table carry in");
      end
  endtask

  task automatic t_increment;  // R3
    apply(8'h7F, 8'h33, 4'b0000, 1'b0, 1'b0);
    check("R3 A plus one", {carry_out_n, result}, {1'b1, 8'h80});
    apply(8'hFF, 8'h00, 4'b0000, 1'b0, 1'b0);
    check("R3 wrap carry", {carry_out_n, result}, {1'b0, 8'h00});
  endtask

  task automatic t_ripple;  // R4
    apply(8'h0F, 8'h01, 4'b1001, 1'b0, 1'b1);
    check("R4 slice boundary", {carry_out_n, result}, {1'b1, 8'h10});
    apply(8'h80, 8'h80, 4'b1001, 1'b0, 1'b1);
    check("R4 top carry", {carry_out_n, result}, {1'b0, 8'h00});
  endtask

  task automatic t_cn_ignored;  // R5
    logic [9:0] first;
    for (int s = 0; s < 16; s++) begin
      apply(8'hA5, 8'h3C, 4'(s), 1'b1, 1'b1);
      first = {all_ones, carry_out_n, result};
      apply(8'hA5, 8'h3C, 4'(s), 1'b1, 1'b0);
      check("R5 carry in ignored", {all_ones, carry_out_n, result}, first);
      check("R5 carry out idle", {9'd0, carry_out_n}, 10'd1);
    end
  endtask

  task automatic t_equal;  // R6
    apply(8'h5A, 8'h5A, 4'b0110, 1'b0, 1'b1);
    check("R6 equal raises flag", {9'd0, all_ones}, 10'd1);
    apply(8'h5A, 8'h5B, 4'b0110, 1'b0, 1'b1);
    check("R6 unequal clears flag", {9'd0, all_ones}, 10'd0);
    apply(8'h00, 8'h00, 4'b1100, 1'b1, 1'b1);
    check("R6 all ones logic", {9'd0, all_ones}, 10'd1);
  endtask

  task automatic t_add_sub;  // R7 R8
    apply(8'd200, 8'd100, 4'b1001, 1'b0, 1'b1);
    check("R7 add overflow", {carry_out_n, result}, {1'b0, 8'd44});
    apply(8'd20, 8'd30, 4'b1001, 1'b0, 1'b1);
    check("R7 add plain", {carry_out_n, result}, {1'b1, 8'd50});
    apply(8'd90, 8'd33, 4'b0110, 1'b0, 1'b0);
    check("R8 sub no borrow", {carry_out_n, result}, {1'b0, 8'd57});
    apply(8'd33, 8'd90, 4'b0110, 1'b0, 1'b0);
    check("R8 sub borrow", {carry_out_n, result}, {1'b1, 8'(33 - 90)});
  endtask

  initial begin
    repeat (2) @(posedge clk);
    t_idle_state();
    t_logic_table();
    t_arith_table();
    t_increment();
    t_ripple();
    t_cn_ignored();
    t_equal();
    t_add_sub();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule